// File: doc/BRIEF.md
# Byte-Wide Host Port Bridge

This block connects an external host with an 8-bit data bus to a buffer of 16-bit words that a local processor also uses. The host reaches the buffer one byte at a time, so each word takes two accesses. A byte-select pin marks which half of the word the current access carries. A two-bit target select picks one of four targets: the buffer address register, the buffer data with automatic address increment, the buffer data without increment, or a small control register.

The control register carries interrupts in both directions. When the host writes it, it can send a one-cycle request to the local processor. The local processor can raise a level interrupt to the host, and the host acknowledges that interrupt by writing the same register. Both sides can read the register. A grant input from the local side's arbiter decides whether host data accesses may use the buffer in the current cycle. Buffer reads have one cycle of latency, and the buffer is outside this block.

Top module: `hostport_bridge`

## Requirements
- R1: After reset the address register is 0, `h_intr` and `loc_intr` are low, `loc_ctl_rd` is 0 and `h_data_out` is 0.
- R2: `h_sel` selects the target: 00 control register, 01 data with post-increment, 10 address register, 11 data without increment. On a write to the address register, the high byte (`h_hi_byte`=1) loads address bits 10:8 from data bits 2:0, and the low byte loads bits 7:0. A read of the address register returns the address zero-extended to 16 bits, one byte per access.
- R3: A data write with the high byte stores that byte only. A data write with the low byte writes {stored high byte, low byte} to the current address, with a single `mem_we` cycle. A high-byte write never writes the buffer.
- R4: A data read with the high byte fetches the word from the buffer (one `mem_re` cycle) and returns its high half. The following low-byte read returns the low half of that same word without accessing the buffer.
- R5: Every read result appears on `h_data_out` after the second rising edge following the strobe cycle, and it holds until the next read.
- R6: With select 01, the address rises by one after each low-byte data access, whether read or write, and wraps from 2047 to 0. With select 11 the address does not change.
- R7: A host low-byte write to the control register with bit 2 set drives `loc_intr` high for exactly one cycle, starting after the next clock edge.
- R8: A local write with bit 3 set raises `h_intr`. A host low-byte control write with bit 3 set clears it. If both happen in the same cycle, the set wins.
- R9: `loc_ctl_rd` bit 3 and host control-register reads (low byte, bit 3) show `h_intr`. The high byte of the control register reads as 0.
- R10: A data access strobed while `mem_grant` is low is ignored. It causes no buffer access, no address change, no change to the stored high byte and no update of `h_data_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_data_in | input | 8 | Host write byte |
| h_data_out | output | 8 | Host read byte (registered) |
| h_sel | input | 2 | Access target select |
| h_hi_byte | input | 1 | 1 = high half of the word, 0 = low half |
| h_write | input | 1 | 1 = write, 0 = read |
| h_strobe | input | 1 | One access per cycle while high |
| h_intr | output | 1 | Interrupt to the host |
| loc_intr | output | 1 | One-cycle request to the local processor |
| loc_ctl_we | input | 1 | Local write to the control register |
| loc_ctl_wdata | input | 16 | Local control write data |
| loc_ctl_rd | output | 16 | Control register as seen locally |
| mem_grant | input | 1 | Host may use the buffer this cycle |
| mem_addr | output | 11 | Buffer word address |
| mem_wdata | output | 16 | Buffer write word |
| mem_we | output | 1 | Buffer write enable |
| mem_re | output | 1 | Buffer read enable, data due next cycle |
| mem_rdata | input | 16 | Buffer read word |

## Verification
The hardest conditions to reach from the ports are those that depend on two independent agents acting in the same cycle. One is a local interrupt set landing in the same cycle as a host acknowledge. The other is a grant withdrawal in the middle of a two-byte word. The bench drives both sides from the same negative edge to force the set/clear collision. It drops `mem_grant` only around a complete high/low byte pair, then reads back the address and the buffer. The address wrap at 2047 is set up directly, and random word writes and read-backs at random addresses, using both data selects, exercise the increment rule against a bench model.

// File: rtl/hpi_pkg.sv
package hpi_pkg;
  typedef enum logic [1:0] {
    SEL_CTL  = 2'b00,
    SEL_DINC = 2'b01,
    SEL_ADDR = 2'b10,
    SEL_DFIX = 2'b11
  } hpi_sel_e;
endpackage

// File: rtl/hpi_addr_reg.sv
module hpi_addr_reg #(
  parameter int AW = 11,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_hi,
  input  logic          load_lo,
  input  logic          inc,
  input  logic [BW-1:0] din,
  output logic [AW-1:0] addr
);
  localparam int AHI = AW - BW;

  always_ff @(posedge clk) begin
    if (rst) addr <= '0;
    else if (load_hi) addr[AW-1:BW] <= din[AHI-1:0];
    else if (load_lo) addr[BW-1:0] <= din;
    else if (inc) addr <= addr + 1'b1;
  end

  p_inc_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    inc && !load_hi && !load_lo |=> addr == AW'($past(addr) + 1'b1));
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load_hi && !load_lo && !inc |=> $stable(addr));
endmodule

// File: rtl/hpi_ctl_reg.sv
module hpi_ctl_reg #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic [BW-1:0] host_din,
  input  logic          loc_we,
  input  logic [DW-1:0] loc_wdata,
  output logic          lreq,
  output logic          hint,
  output logic [DW-1:0] ctl_word
);
  localparam int REQ_BIT  = 2;
  localparam int HINT_BIT = 3;

  logic set_h, clr_h;
  assign set_h = loc_we && loc_wdata[HINT_BIT];
  assign clr_h = host_wr && host_din[HINT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      lreq <= 1'b0;
      hint <= 1'b0;
    end else begin
      lreq <= host_wr && host_din[REQ_BIT];
      if (set_h) hint <= 1'b1;
      else if (clr_h) hint <= 1'b0;
    end
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[REQ_BIT]  = lreq;
    ctl_word[HINT_BIT] = hint;
  end

  p_req_cause_r7: assert property (@(posedge clk) disable iff (rst)
    lreq |-> $past(host_wr && host_din[REQ_BIT]));
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    loc_we && loc_wdata[HINT_BIT] |=> hint);
  p_host_clear_r8: assert property (@(posedge clk) disable iff (rst)
    host_wr && host_din[HINT_BIT] && !(loc_we && loc_wdata[HINT_BIT]) |=> !hint);
endmodule

// File: rtl/hpi_rd_path.sv
module hpi_rd_path
  import hpi_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  hpi_sel_e      sel,
  input  logic          hi,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] ctl_word,
  input  logic [DW-1:0] mem_rdata,
  output logic [BW-1:0] dout
);
  logic          p_req, p_hi;
  hpi_sel_e      p_sel;
  logic [BW-1:0] lo_hold;
  logic [DW-1:0] addr_w;

  assign addr_w = DW'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_req <= 1'b0;
      p_hi  <= 1'b0;
      p_sel <= SEL_CTL;
    end else begin
      p_req <= req;
      p_hi  <= hi;
      p_sel <= sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      lo_hold <= '0;
    end else if (p_req) begin
      case (p_sel)
        SEL_CTL:  dout <= p_hi ? ctl_word[DW-1:BW] : ctl_word[BW-1:0];
        SEL_ADDR: dout <= p_hi ? addr_w[DW-1:BW] : addr_w[BW-1:0];
        default: begin
          if (p_hi) begin
            dout    <= mem_rdata[DW-1:BW];
            lo_hold <= mem_rdata[BW-1:0];
          end else begin
            dout <= lo_hold;
          end
        end
      endcase
    end
  end

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !p_req |=> $stable(dout));
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
  import hpi_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] h_data_in,
  output logic [BW-1:0] h_data_out,
  input  logic [1:0]    h_sel,
  input  logic          h_hi_byte,
  input  logic          h_write,
  input  logic          h_strobe,
  output logic          h_intr,
  output logic          loc_intr,
  input  logic          loc_ctl_we,
  input  logic [DW-1:0] loc_ctl_wdata,
  output logic [DW-1:0] loc_ctl_rd,
  input  logic          mem_grant,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata
);
  hpi_sel_e      sel;
  logic          is_data, data_ok, reg_rd, rd_req;
  logic          ld_hi, ld_lo, inc, ctl_wr;
  logic [BW-1:0] wr_hi_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] ctl_word;

  assign sel     = hpi_sel_e'(h_sel);
  assign is_data = (sel == SEL_DINC) || (sel == SEL_DFIX);
  assign data_ok = h_strobe && is_data && mem_grant;
  assign reg_rd  = h_strobe && !is_data;
  assign rd_req  = !h_write && (reg_rd || data_ok);

  assign mem_we    = data_ok && h_write && !h_hi_byte;
  assign mem_re    = data_ok && !h_write && h_hi_byte;
  assign mem_addr  = addr_q;
  assign mem_wdata = {wr_hi_q, h_data_in};

  assign ld_hi  = h_strobe && h_write && sel == SEL_ADDR && h_hi_byte;
  assign ld_lo  = h_strobe && h_write && sel == SEL_ADDR && !h_hi_byte;
  assign inc    = data_ok && !h_hi_byte && sel == SEL_DINC;
  assign ctl_wr = h_strobe && h_write && sel == SEL_CTL && !h_hi_byte;

  always_ff @(posedge clk) begin
    if (rst) wr_hi_q <= '0;
    else if (data_ok && h_write && h_hi_byte) wr_hi_q <= h_data_in;
  end

  hpi_addr_reg #(.AW(AW), .BW(BW)) u_addr (
    .clk(clk), .rst(rst), .load_hi(ld_hi), .load_lo(ld_lo), .inc(inc),
    .din(h_data_in), .addr(addr_q)
  );

  hpi_ctl_reg #(.DW(DW), .BW(BW)) u_ctl (
    .clk(clk), .rst(rst), .host_wr(ctl_wr), .host_din(h_data_in),
    .loc_we(loc_ctl_we), .loc_wdata(loc_ctl_wdata),
    .lreq(loc_intr), .hint(h_intr), .ctl_word(ctl_word)
  );

  assign loc_ctl_rd = ctl_word;

  hpi_rd_path #(.AW(AW), .DW(DW), .BW(BW)) u_rd (
    .clk(clk), .rst(rst), .req(rd_req), .sel(sel), .hi(h_hi_byte),
    .addr(addr_q), .ctl_word(ctl_word), .mem_rdata(mem_rdata), .dout(h_data_out)
  );

  p_we_low_only_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !h_hi_byte && h_write && h_strobe);
  p_re_high_only_r4: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> h_hi_byte && !h_write && h_strobe);
  p_one_access_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re}));
  p_no_grant_r10: assert property (@(posedge clk) disable iff (rst)
    !mem_grant |-> !mem_we && !mem_re);
endmodule

// File: tb/sim_hostport_bridge.sv
`timescale 1ns/1ps
module sim_hostport_bridge;
  logic        clk = 0, rst = 1;
  logic [7:0]  h_data_in = 0, h_data_out;
  logic [1:0]  h_sel = 0;
  logic        h_hi_byte = 0, h_write = 0, h_strobe = 0;
  logic        h_intr, loc_intr;
  logic        loc_ctl_we = 0;
  logic [15:0] loc_ctl_wdata = 0, loc_ctl_rd;
  logic        mem_grant = 1;
  logic [10:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_we, mem_re;

  int n_chk = 0, n_bad = 0, re_cnt = 0;
  bit done = 0;
  logic [15:0] bm [0:2047];

  always #2 clk = ~clk;

  hostport_bridge u0 (
    .clk(clk), .rst(rst), .h_data_in(h_data_in), .h_data_out(h_data_out),
    .h_sel(h_sel), .h_hi_byte(h_hi_byte), .h_write(h_write), .h_strobe(h_strobe),
    .h_intr(h_intr), .loc_intr(loc_intr), .loc_ctl_we(loc_ctl_we),
    .loc_ctl_wdata(loc_ctl_wdata), .loc_ctl_rd(loc_ctl_rd), .mem_grant(mem_grant),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_we) bm[mem_addr] <= mem_wdata;
    if (mem_re) begin
      mem_rdata <= bm[mem_addr];
      re_cnt <= re_cnt + 1;
    end
  end

  function automatic logic [10:0] next_addr(input logic [10:0] a, input logic [1:0] s);
    return (s == 2'b01) ? 11'(a + 11'd1) : a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hop(input logic [1:0] s, input logic hi, input logic wr, input logic [7:0] d);
    @(negedge clk);
    h_sel = s; h_hi_byte = hi; h_write = wr; h_data_in = d; h_strobe = 1;
    @(negedge clk);
    h_strobe = 0;
    @(negedge clk);
  endtask

  task automatic set_addr(input logic [10:0] a);
    hop(2'b10, 1, 1, {5'd0, a[10:8]});
    hop(2'b10, 0, 1, a[7:0]);
  endtask

  task automatic rd_addr(output logic [15:0] v);
    hop(2'b10, 1, 0, 0); v[15:8] = h_data_out;
    hop(2'b10, 0, 0, 0); v[7:0] = h_data_out;
  endtask

  task automatic wr_word(input logic [1:0] s, input logic [15:0] w);
    hop(s, 1, 1, w[15:8]);
    hop(s, 0, 1, w[7:0]);
  endtask

  task automatic rd_word(input logic [1:0] s, output logic [15:0] w);
    hop(s, 1, 0, 0); w[15:8] = h_data_out;
    hop(s, 0, 0, 0); w[7:0] = h_data_out;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, w;
    int r0;
    logic [7:0] keep;
    for (int i = 0; i < 2048; i++) bm[i] = 16'h0000;
    mem_rdata = 0;
    r0 = $urandom(32'd7);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    chk("R1 dout", h_data_out, 0);
    chk("R1 h_intr", h_intr, 0);
    chk("R1 loc_intr", loc_intr, 0);
    chk("R1 loc_ctl_rd", loc_ctl_rd, 0);
    rd_addr(v); chk("R1 addr", v, 0);

    // R2 address register bytes
    set_addr(11'h523);
    rd_addr(v); chk("R2 addr readback", v, 16'h0523);

    // R3 write only on low byte; R6 sel 11 keeps address
    hop(2'b11, 1, 1, 8'hBE);
    chk("R3 no write on high byte", bm[11'h523], 0);
    hop(2'b11, 0, 1, 8'hEF);
    chk("R3 word written", bm[11'h523], 16'hBEEF);
    rd_addr(v); chk("R6 fixed select keeps addr", v, 16'h0523);

    // R4/R5 read path
    v = 16'h0;
    r0 = re_cnt;
    hop(2'b11, 1, 0, 0); chk("R5 high byte after two edges", h_data_out, 8'hBE);
    bm[11'h523] = 16'h1111;
    hop(2'b11, 0, 0, 0); chk("R4 low byte from held word", h_data_out, 8'hEF);
    chk("R4 single fetch", re_cnt - r0, 1);
    @(negedge clk); @(negedge clk);
    chk("R5 output holds", h_data_out, 8'hEF);

    // R6 wrap at top
    set_addr(11'h7FF);
    wr_word(2'b01, 16'h1234);
    chk("R6 word at top", bm[11'h7FF], 16'h1234);
    rd_addr(v); chk("R6 wrap to 0", v, 16'h0000);

    // R10 grant low
    set_addr(11'h005);
    hop(2'b01, 1, 1, 8'hA5);
    mem_grant = 0;
    wr_word(2'b01, 16'h7788);
    hop(2'b01, 1, 0, 0);
    keep = h_data_out;
    hop(2'b01, 0, 0, 0);
    mem_grant = 1;
    chk("R10 no buffer write", bm[11'h005], 0);
    chk("R10 dout unchanged", h_data_out, keep);
    rd_addr(v); chk("R10 addr unchanged", v, 16'h0005);
    hop(2'b11, 0, 1, 8'h01);
    chk("R10 stored high byte kept", bm[11'h005], 16'hA501);

    // R7 one-cycle local request
    @(negedge clk);
    h_sel = 2'b00; h_hi_byte = 0; h_write = 1; h_data_in = 8'h04; h_strobe = 1;
    @(negedge clk);
    h_strobe = 0;
    chk("R7 loc_intr high", loc_intr, 1);
    @(negedge clk);
    chk("R7 loc_intr one cycle", loc_intr, 0);

    // R8/R9 host interrupt
    @(negedge clk); loc_ctl_we = 1; loc_ctl_wdata = 16'h0008;
    @(negedge clk); loc_ctl_we = 0;
    chk("R8 local set", h_intr, 1);
    chk("R9 local view", loc_ctl_rd[3], 1);
    hop(2'b00, 0, 0, 0); chk("R9 host ctl low", h_data_out, 8'h08);
    hop(2'b00, 1, 0, 0); chk("R9 host ctl high", h_data_out, 8'h00);
    @(negedge clk);
    h_sel = 2'b00; h_hi_byte = 0; h_write = 1; h_data_in = 8'h08; h_strobe = 1;
    loc_ctl_we = 1; loc_ctl_wdata = 16'h0008;
    @(negedge clk); h_strobe = 0; loc_ctl_we = 0;
    chk("R8 set wins", h_intr, 1);
    hop(2'b00, 0, 1, 8'h08);
    chk("R8 host clear", h_intr, 0);
    hop(2'b00, 1, 1, 8'h08);
    chk("R2 high ctl byte write no effect", h_intr, 0);

    // Random word traffic
    for (int it = 0; it < 150; it++) begin
      logic [10:0] a;
      logic [1:0]  s;
      a = 11'($urandom);
      w = 16'($urandom);
      s = ($urandom % 2) ? 2'b01 : 2'b11;
      set_addr(a);
      wr_word(s, w);
      rd_addr(v); chk("R6 random addr step", v, {5'd0, next_addr(a, s)});
      set_addr(a);
      rd_word(s, v); chk("R4 random readback", v, w);
      chk("R3 random buffer", bm[a], w);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule